// File: doc/BRIEF.md
# Mode-Programmed Burst Column Sequencer

This block models the memory-side mode register of a mobile DDR SDRAM, together with the column sequencer that the register controls. A load-mode command stores three settings: the burst length, the burst type and the read latency. The block refuses a load while it is busy or while any bank is active. It also flags a load that carries a reserved encoding, and in both cases it keeps the stored settings.

A read or write command starts a burst. In each cycle of the burst the block gives out one column address, in the order that the stored length and type set, starting from the column given with the command. For a read it also raises a data-valid strobe after the stored latency. A command that arrives while the block is busy is dropped.

Top module: `burst_mode_seq`

## Requirements
- R1: After reset the stored settings are burst-length code 001, sequential type, latency code 011. col_valid_o, data_valid_o, busy_o, lmr_reject_o and mode_err_o are all 0.
- R2: A load is cmd_i = 01 with ba_i = 00, banks_idle_i = 1 and busy_o = 0. If its encoding is valid, the stored settings take the new values from the edge that samples it onward. The fields are addr_i[2:0] for length (001 = 2, 010 = 4, 011 = 8), addr_i[3] for type (0 = sequential, 1 = interleaved), addr_i[6:4] for latency (010 = 2, 011 = 3), and addr_i[12:7], which must be zero.
- R3: A load with ba_i other than 00 has no effect on the stored settings, mode_err_o or lmr_reject_o.
- R4: A load with a reserved length code, a reserved latency code or a nonzero addr_i[12:7] sets mode_err_o and leaves the stored settings unchanged. The next accepted valid load clears mode_err_o.
- R5: A load sampled while busy_o = 1 or banks_idle_i = 0 raises lmr_reject_o for exactly one cycle. It leaves the stored settings and mode_err_o unchanged.
- R6: A read (cmd_i = 10) or write (cmd_i = 11) sampled while busy_o = 0 raises col_valid_o for exactly BL cycles, starting in the cycle after the sampling edge. busy_o is high during these cycles.
- R7: In sequential type, the low log2(BL) bits of beat i are (start + i) mod BL.
- R8: In interleaved type, the low log2(BL) bits of beat i are start XOR i.
- R9: The column bits above the low log2(BL) bits equal those of addr_i for every beat.
- R10: For a read, data_valid_o is high for BL cycles, starting latency-1 cycles after the first col_valid_o cycle. busy_o stays high until the last of those cycles.
- R11: A write never raises data_valid_o, and col_is_read_o is 1 only during read beats.
- R12: A read or write sampled while busy_o = 1 is ignored, and the burst in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | Command: 00 none, 01 load mode, 10 read, 11 write |
| ba_i | input | BA_W | Bank address; must be 0 for a load |
| addr_i | input | ADDR_W | Mode fields for a load, start column for a read or write |
| banks_idle_i | input | 1 | High when all banks are idle |
| col_valid_o | output | 1 | A burst beat is being given out |
| col_addr_o | output | COL_W | Column of the current beat |
| col_is_read_o | output | 1 | The current beat belongs to a read |
| data_valid_o | output | 1 | Read data strobe |
| busy_o | output | 1 | A burst or its read data is in progress |
| lmr_reject_o | output | 1 | One-cycle pulse for a refused load |
| mode_err_o | output | 1 | The last evaluated load had a reserved encoding |
| mode_bl_o | output | 3 | Stored burst-length code |
| mode_bt_o | output | 1 | Stored burst type |
| mode_cl_o | output | 3 | Stored latency code |

## Verification
The bench checks the wrap point of each burst length when the start column sits near the top of the group. A design that carries past the group boundary would change the upper column bits, and one that confuses XOR with addition would reorder interleaved beats. It times data_valid_o against both latencies, where an off-by-one pipeline would shift the strobe or cut busy_o short. It issues loads during a burst, with a bank active, with a nonzero bank address and with each kind of reserved field. A design that wrote the register anyway would show new settings, and one that dropped the error flag would leave mode_err_o low. It also issues a read on top of a running burst, which must not restart the column sequence.

// File: rtl/burst_mode_pkg.sv
package burst_mode_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_LMR = 2'b01,
        CMD_RD  = 2'b10,
        CMD_WR  = 2'b11
    } cmd_e;

    typedef struct packed {
        logic [2:0] bl_code;
        logic       bt;
        logic [2:0] cl_code;
    } mode_t;

    localparam mode_t MODE_RST = '{bl_code: 3'b001, bt: 1'b0, cl_code: 3'b011};

    // Length codes 1..3 give 2, 4, 8; latency codes 2 and 3; operating field zero.
    function automatic logic fields_legal(input logic [2:0] bl, input logic [2:0] cl,
                                          input logic opm_zero);
        return (bl >= 3'd1) && (bl <= 3'd3) && (cl == 3'd2 || cl == 3'd3) && opm_zero;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_mode_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              block_i,
    input  logic [ADDR_W-1:0] addr_i,
    output mode_t             mode_o,
    output logic              err_o,
    output logic              reject_o
);

    localparam int OPM_LSB = 7;

    typedef struct packed {
        mode_t mode;
        logic  err;
        logic  reject;
    } mr_state_t;

    mr_state_t s_d, s_q;
    mode_t     cand;
    logic      opm_zero;

    always_comb begin
        cand.bl_code = addr_i[2:0];
        cand.bt      = addr_i[3];
        cand.cl_code = addr_i[6:4];
        opm_zero     = (addr_i[ADDR_W-1:OPM_LSB] == '0);

        s_d        = s_q;
        s_d.reject = 1'b0;
        if (load_i) begin
            if (block_i) begin
                s_d.reject = 1'b1;
            end else if (fields_legal(cand.bl_code, cand.cl_code, opm_zero)) begin
                s_d.mode = cand;
                s_d.err  = 1'b0;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_RST, err: 1'b0, reject: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o   = s_q.mode;
    assign err_o    = s_q.err;
    assign reject_o = s_q.reject;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [2:0]       idx_i,
    input  logic [2:0]       bl_code_i,
    input  logic             bt_i,
    output logic [COL_W-1:0] col_o
);

    logic [3:0] span;
    logic [2:0] mask;
    logic [2:0] low;

    always_comb begin
        span  = 4'd1 << bl_code_i[1:0];
        mask  = 3'(span - 4'd1);
        low   = bt_i ? (start_i[2:0] ^ idx_i) : (start_i[2:0] + idx_i);
        col_o = start_i;
        col_o[2:0] = (start_i[2:0] & ~mask) | (low & mask);
    end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_mode_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_read_i,
    input  logic [COL_W-1:0] col_i,
    input  mode_t            mode_i,
    output logic             active_o,
    output logic [2:0]       idx_o,
    output logic [COL_W-1:0] start_col_o,
    output logic [2:0]       bl_code_o,
    output logic             bt_o,
    output logic             beat_rd_o,
    output logic             data_valid_o,
    output logic             busy_o
);

    localparam int CNT_W  = 4;
    localparam int PIPE_D = 2;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        idx;
        logic [COL_W-1:0]  col;
        logic [2:0]        bl;
        logic              bt;
        logic              cl3;
        logic              rd;
        logic [PIPE_D-1:0] pipe;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       beat_live;

    always_comb begin
        beat_live = (s_q.cnt != '0);
        s_d       = s_q;
        if (beat_live) begin
            s_d.cnt = s_q.cnt - 1'b1;
            s_d.idx = s_q.idx + 1'b1;
        end
        s_d.pipe[0] = beat_live && s_q.rd;
        s_d.pipe[1] = s_q.pipe[0] && s_q.cl3;
        if (start_i) begin
            s_d.cnt = CNT_W'(1) << mode_i.bl_code[1:0];
            s_d.idx = '0;
            s_d.col = col_i;
            s_d.bl  = mode_i.bl_code;
            s_d.bt  = mode_i.bt;
            s_d.cl3 = (mode_i.cl_code == 3'd3);
            s_d.rd  = is_read_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o     = beat_live;
    assign idx_o        = s_q.idx;
    assign start_col_o  = s_q.col;
    assign bl_code_o    = s_q.bl;
    assign bt_o         = s_q.bt;
    assign beat_rd_o    = beat_live && s_q.rd;
    assign data_valid_o = s_q.cl3 ? s_q.pipe[1] : s_q.pipe[0];
    assign busy_o       = beat_live || (s_q.pipe != '0);

endmodule

// File: rtl/burst_mode_seq.sv
module burst_mode_seq
    import burst_mode_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              banks_idle_i,
    output logic              col_valid_o,
    output logic [COL_W-1:0]  col_addr_o,
    output logic              col_is_read_o,
    output logic              data_valid_o,
    output logic              busy_o,
    output logic              lmr_reject_o,
    output logic              mode_err_o,
    output logic [2:0]        mode_bl_o,
    output logic              mode_bt_o,
    output logic [2:0]        mode_cl_o
);

    cmd_e             cmd;
    mode_t            mode;
    logic             load, block, start, is_read;
    logic [2:0]       idx, bl_code;
    logic             bt;
    logic [COL_W-1:0] start_col;

    always_comb begin
        cmd     = cmd_e'(cmd_i);
        load    = (cmd == CMD_LMR) && (ba_i == '0);
        block   = busy_o || !banks_idle_i;
        is_read = (cmd == CMD_RD);
        start   = (cmd == CMD_RD || cmd == CMD_WR) && !busy_o;
    end

    burst_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .block_i  (block),
        .addr_i   (addr_i),
        .mode_o   (mode),
        .err_o    (mode_err_o),
        .reject_o (lmr_reject_o)
    );

    burst_seq_ctrl #(.COL_W(COL_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .is_read_i    (is_read),
        .col_i        (addr_i[COL_W-1:0]),
        .mode_i       (mode),
        .active_o     (col_valid_o),
        .idx_o        (idx),
        .start_col_o  (start_col),
        .bl_code_o    (bl_code),
        .bt_o         (bt),
        .beat_rd_o    (col_is_read_o),
        .data_valid_o (data_valid_o),
        .busy_o       (busy_o)
    );

    burst_col_gen #(.COL_W(COL_W)) u_col (
        .start_i   (start_col),
        .idx_i     (idx),
        .bl_code_i (bl_code),
        .bt_i      (bt),
        .col_o     (col_addr_o)
    );

    assign mode_bl_o = mode.bl_code;
    assign mode_bt_o = mode.bt;
    assign mode_cl_o = mode.cl_code;

endmodule

// File: rtl/burst_mode_chk.sv
module burst_mode_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             col_valid_o,
    input logic [COL_W-1:0] col_addr_o,
    input logic             col_is_read_o,
    input logic             data_valid_o,
    input logic             busy_o,
    input logic             lmr_reject_o,
    input logic             mode_err_o,
    input logic [2:0]       mode_bl_o,
    input logic             mode_bt_o,
    input logic [2:0]       mode_cl_o
);

    a_r6_beat_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o |-> busy_o);

    a_r10_strobe_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> busy_o);

    a_r5_reject_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        lmr_reject_o |-> ($stable({mode_bl_o, mode_bt_o, mode_cl_o}) && $stable(mode_err_o)));

    a_r4_error_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_err_o) |-> $stable({mode_bl_o, mode_bt_o, mode_cl_o}));

    a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && $past(col_valid_o)) |->
            (col_addr_o[COL_W-1:3] == $past(col_addr_o[COL_W-1:3])));

    a_r11_no_strobe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !col_is_read_o) |-> !data_valid_o);

endmodule

bind burst_mode_seq burst_mode_chk #(.COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .col_valid_o   (col_valid_o),
    .col_addr_o    (col_addr_o),
    .col_is_read_o (col_is_read_o),
    .data_valid_o  (data_valid_o),
    .busy_o        (busy_o),
    .lmr_reject_o  (lmr_reject_o),
    .mode_err_o    (mode_err_o),
    .mode_bl_o     (mode_bl_o),
    .mode_bt_o     (mode_bt_o),
    .mode_cl_o     (mode_cl_o)
);

// File: tb/tb_burst_mode_seq.sv
module tb_burst_mode_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int COL_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cmd_i = 2'b00;
    logic [BA_W-1:0]   ba_i = '0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              banks_idle_i = 1'b1;
    logic              col_valid_o, col_is_read_o, data_valid_o, busy_o;
    logic              lmr_reject_o, mode_err_o, mode_bt_o;
    logic [COL_W-1:0]  col_addr_o;
    logic [2:0]        mode_bl_o, mode_cl_o;

    int checks = 0;
    int errors = 0;
    int m_bl = 1, m_bt = 0, m_cl = 3, m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_mode_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ba_i(ba_i), .addr_i(addr_i),
        .banks_idle_i(banks_idle_i), .col_valid_o(col_valid_o), .col_addr_o(col_addr_o),
        .col_is_read_o(col_is_read_o), .data_valid_o(data_valid_o), .busy_o(busy_o),
        .lmr_reject_o(lmr_reject_o), .mode_err_o(mode_err_o), .mode_bl_o(mode_bl_o),
        .mode_bt_o(mode_bt_o), .mode_cl_o(mode_cl_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_col(input int s, input int i, input int bl, input int bt);
        int len, base, off;
        len  = 1 << bl;
        base = s - (s % len);
        off  = s % len;
        if (bt == 1) return base + (off ^ i);
        return base + ((off + i) % len);
    endfunction

    function automatic logic [ADDR_W-1:0] mk_mode(input int opm, input int cl, input int bt,
                                                  input int bl);
        return {6'(opm), 3'(cl), 1'(bt), 3'(bl)};
    endfunction

    task automatic chk_mode(input string req);
        chk({req, " bl"}, int'(mode_bl_o), m_bl);
        chk({req, " bt"}, int'(mode_bt_o), m_bt);
        chk({req, " cl"}, int'(mode_cl_o), m_cl);
        chk({req, " err"}, int'(mode_err_o), m_err);
    endtask

    task automatic do_lmr(input int ba, input logic [ADDR_W-1:0] a, input logic idle,
                          input string req);
        int exp_rej;
        exp_rej = 0;
        cmd_i = 2'b01; ba_i = BA_W'(ba); addr_i = a; banks_idle_i = idle;
        tick();
        cmd_i = 2'b00; ba_i = '0; banks_idle_i = 1'b1;
        if (ba == 0) begin
            if (!idle) exp_rej = 1;
            else if ((a[2:0] >= 1) && (a[2:0] <= 3) && (a[6:4] == 2 || a[6:4] == 3)
                     && (a[12:7] == 0)) begin
                m_bl = int'(a[2:0]); m_bt = int'(a[3]); m_cl = int'(a[6:4]); m_err = 0;
            end else m_err = 1;
        end
        chk({req, " reject"}, int'(lmr_reject_o), exp_rej);
        chk_mode(req);
        tick();
        chk({req, " reject pulse"}, int'(lmr_reject_o), 0);
    endtask

    // inj: 0 none, 1 load during burst, 2 read during burst
    task automatic do_burst(input logic rd, input int col, input int inj, input string req);
        int len, lat, tot, k;
        len = 1 << m_bl;
        lat = m_cl;
        tot = rd ? len + lat - 1 : len;
        cmd_i = rd ? 2'b10 : 2'b11; addr_i = ADDR_W'(col);
        tick();
        if (inj == 1) begin cmd_i = 2'b01; ba_i = '0; addr_i = mk_mode(0, 2, 1, 3); end
        else if (inj == 2) begin cmd_i = 2'b10; addr_i = ADDR_W'(col ^ 10'h155); end
        else cmd_i = 2'b00;
        for (k = 0; k <= tot; k++) begin
            chk({req, " R6 col_valid"}, int'(col_valid_o), (k < len) ? 1 : 0);
            if (k < len) begin
                chk({req, (m_bt == 1) ? " R8 order" : " R7 order"}, int'(col_addr_o),
                    exp_col(col, k, m_bl, m_bt));
                chk({req, " R9 upper"}, int'(col_addr_o) >> 3, col >> 3);
                chk({req, " R11 is_read"}, int'(col_is_read_o), rd ? 1 : 0);
            end
            chk({req, " R10 data_valid"}, int'(data_valid_o),
                (rd && k >= lat - 1 && k < lat - 1 + len) ? 1 : 0);
            chk({req, " R6 busy"}, int'(busy_o), (k < tot) ? 1 : 0);
            if (k == 1 && inj == 1) begin
                chk({req, " R5 reject busy"}, int'(lmr_reject_o), 1);
                chk_mode({req, " R5"});
            end
            tick();
            if (k == 0) cmd_i = 2'b00;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        chk("R1 col_valid", int'(col_valid_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 data_valid", int'(data_valid_o), 0);
        chk("R1 reject", int'(lmr_reject_o), 0);
        chk_mode("R1");
        rst_n = 1'b1;
        tick();

        do_burst(1'b1, 10'h0B5, 0, "R1 default read");
        do_lmr(0, mk_mode(0, 2, 0, 2), 1'b1, "R2 bl4 seq cl2");
        do_burst(1'b1, 10'h0B7, 0, "R7 bl4 wrap");
        do_lmr(0, mk_mode(0, 3, 1, 3), 1'b1, "R2 bl8 intl cl3");
        do_burst(1'b1, 10'h3FD, 0, "R8 bl8 read");
        do_burst(1'b0, 10'h12A, 0, "R11 bl8 write");
        do_lmr(1, mk_mode(0, 2, 0, 1), 1'b1, "R3 bank1");
        do_lmr(2, mk_mode(0, 2, 0, 1), 1'b1, "R3 bank2");
        do_lmr(0, mk_mode(0, 3, 0, 0), 1'b1, "R4 bl reserved");
        do_lmr(0, mk_mode(0, 1, 0, 2), 1'b1, "R4 cl reserved");
        do_lmr(0, mk_mode(5, 2, 0, 2), 1'b1, "R4 opm nonzero");
        do_lmr(0, mk_mode(0, 2, 0, 2), 1'b0, "R5 banks active");
        do_lmr(0, mk_mode(0, 2, 0, 1), 1'b1, "R4 clear err");
        do_burst(1'b0, 10'h001, 1, "R5 load in write");
        do_burst(1'b1, 10'h2FF, 2, "R12 read in read");
        do_lmr(0, mk_mode(0, 2, 0, 3), 1'b1, "R7 bl8 seq cl2");
        do_burst(1'b1, 10'h1FE, 2, "R12 bl8 seq");

        for (int n = 0; n < 300; n++) begin
            int r, c;
            r = int'($urandom % 5);
            c = int'($urandom % 1024);
            case (r)
                0: do_lmr(0, mk_mode(0, 2 + int'($urandom % 2), int'($urandom % 2),
                                     1 + int'($urandom % 3)), 1'b1, "R2 rnd");
                1: do_lmr(int'($urandom % 4), ADDR_W'($urandom),
                          1'($urandom % 4 != 0), "R4 rnd");
                2: do_burst(1'b1, c, int'($urandom % 3), "R10 rnd");
                default: do_burst(1'b0, c, int'($urandom % 3), "R11 rnd");
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule